// File: doc/BRIEF.md
# Next-PC Instruction Fetch Sequencer

This block owns the program counter of a single-cycle processor and picks its successor on every rising clock edge. The current value is driven out as the instruction-memory address. While that instruction executes, the decoder and the ALU return three qualifiers: a branch-instruction flag, the ALU zero flag and a jump flag. The instruction also supplies two fields, a 16-bit immediate and a 26-bit jump target.

Two adders run in parallel. One forms the fall-through address, PC + 4. The other adds the sign-extended, word-scaled immediate to that sum to form the branch target. A branch selector picks the branch target only when the branch flag and the zero flag are both high. A jump selector follows it. When the jump flag is set, it replaces the result with the jump target spliced below the top four bits of the current PC.

Top module: `pc_fetch_seq`

## Requirements
- R1: A synchronous active-high `rst` loads the PC with 0 on the next rising edge, whatever the other inputs are.
- R2: With `is_branch` = 0 and `is_jump` = 0, the PC advances by 4 on each rising edge.
- R3: With `is_branch` = 1, `alu_zero` = 1 and `is_jump` = 0, the next PC is PC + 4 + (imm sign-extended from bit 15, shifted left by 2). A negative immediate moves the PC backwards.
- R4: The branch is not taken unless both `is_branch` and `alu_zero` are 1. Branch = 1 with zero = 0 gives PC + 4. Zero = 1 with branch = 0 also gives PC + 4.
- R5: With `is_jump` = 1, the next PC is {PC[31:28], jump_tgt[25:0], 2'b00}. The top nibble is kept from the current PC.
- R6: `is_jump` = 1 takes priority over a taken branch, for every value of `is_branch` and `alu_zero`.
- R7: Bits [1:0] of the PC are 0 after every update, on every path.
- R8: Address arithmetic wraps modulo 2^32 and raises no flag. A backward branch from 0 lands near the top of the address space, and PC + 4 from 0xFFFFFFFC gives 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the PC updates on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| is_branch | input | 1 | The current instruction is a conditional branch |
| alu_zero | input | 1 | The ALU result is zero |
| is_jump | input | 1 | The current instruction is an absolute jump |
| imm_field | input | 16 | Branch immediate, in words, signed |
| jump_tgt | input | 26 | Jump target word index |
| fetch_addr | output | 32 | Current PC, used as the instruction-memory address |

## Verification
The bench walks the PC from reset through plain sequential steps, which show that the fall-through adder works alone. It then runs forward and backward branches, which separate the sign extension from the scaling of the immediate. The two half-qualified branch cases (branch without zero, zero without branch) show that the select is an AND and not either flag alone. A jump issued alongside a taken branch checks the priority between the selectors. Jumps made after the PC has wrapped into the top nibble show that the upper bits come from the current PC and not from zero, and the wrap cases show that the arithmetic is modulo 2^32.

// File: rtl/fetch_pkg.sv
package fetch_pkg;

    localparam int unsigned DEF_ADDR_W = 32;
    localparam int unsigned DEF_IMM_W  = 16;
    localparam int unsigned DEF_TGT_W  = 26;
    localparam int unsigned DEF_STEP   = 4;

    // Which source feeds the PC register on the next edge
    typedef enum logic [1:0] {
        SRC_SEQ    = 2'd0,
        SRC_BRANCH = 2'd1,
        SRC_JUMP   = 2'd2
    } next_src_e;

    // Decoded qualifiers that drive the source choice
    typedef struct packed {
        logic take_branch;
        logic take_jump;
    } fetch_sel_t;

    function automatic next_src_e pick_src(input fetch_sel_t s);
        if (s.take_jump)
            return SRC_JUMP;
        else if (s.take_branch)
            return SRC_BRANCH;
        else
            return SRC_SEQ;
    endfunction

endpackage

// File: rtl/pc_adder.sv
module pc_adder #(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    output logic [W-1:0] sum
);
    // Carry out is dropped: address space wraps modulo 2^W
    always_comb sum = op_a + op_b;
endmodule

// File: rtl/branch_offset.sv
module branch_offset #(
    parameter int unsigned ADDR_W  = 32,
    parameter int unsigned IMM_W   = 16,
    parameter int unsigned ALIGN_W = 2
) (
    input  logic [IMM_W-1:0]  imm,
    output logic [ADDR_W-1:0] byte_off
);
    localparam int unsigned SEXT_W = ADDR_W - IMM_W - ALIGN_W;

    generate
        if (SEXT_W > 0) begin : g_ext
            always_comb byte_off = {{SEXT_W{imm[IMM_W-1]}}, imm, {ALIGN_W{1'b0}}};
        end else begin : g_trunc
            logic [IMM_W+ALIGN_W-1:0] wide;
            always_comb begin
                wide     = {imm, {ALIGN_W{1'b0}}};
                byte_off = wide[ADDR_W-1:0];
            end
        end
    endgenerate
endmodule

// File: rtl/pc_path_sel.sv
module pc_path_sel
    import fetch_pkg::*;
(
    input  logic      is_branch,
    input  logic      alu_zero,
    input  logic      is_jump,
    output next_src_e src
);
    fetch_sel_t sel;

    always_comb begin
        sel.take_branch = is_branch & alu_zero;
        sel.take_jump   = is_jump;
        src             = pick_src(sel);
    end
endmodule

// File: rtl/next_pc_mux.sv
module next_pc_mux
    import fetch_pkg::*;
#(
    parameter int unsigned ADDR_W  = 32,
    parameter int unsigned TGT_W   = 26,
    parameter int unsigned ALIGN_W = 2
) (
    input  next_src_e                       src,
    input  logic [ADDR_W-1:0]               seq_pc,
    input  logic [ADDR_W-1:0]               br_pc,
    input  logic [ADDR_W-TGT_W-ALIGN_W-1:0] pc_hi,
    input  logic [TGT_W-1:0]                tgt,
    output logic [ADDR_W-1:0]               next_pc
);
    logic [ADDR_W-1:0] stage1;
    logic [ADDR_W-1:0] jump_pc;

    always_comb begin
        // Stage 1: fall-through or branch target
        stage1  = (src == SRC_BRANCH) ? br_pc : seq_pc;
        // Stage 2: the jump splice overrides stage 1
        jump_pc = {pc_hi, tgt, {ALIGN_W{1'b0}}};
        next_pc = (src == SRC_JUMP) ? jump_pc : stage1;
    end
endmodule

// File: rtl/pc_fetch_seq.sv
module pc_fetch_seq
    import fetch_pkg::*;
#(
    parameter int unsigned ADDR_W = DEF_ADDR_W,
    parameter int unsigned IMM_W  = DEF_IMM_W,
    parameter int unsigned TGT_W  = DEF_TGT_W,
    parameter int unsigned STEP   = DEF_STEP
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              is_branch,
    input  logic              alu_zero,
    input  logic              is_jump,
    input  logic [IMM_W-1:0]  imm_field,
    input  logic [TGT_W-1:0]  jump_tgt,
    output logic [ADDR_W-1:0] fetch_addr
);
    localparam int unsigned ALIGN_W = $clog2(STEP);
    localparam int unsigned HI_W    = ADDR_W - TGT_W - ALIGN_W;
    localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(STEP);

    logic [ADDR_W-1:0] pc_q;
    logic [ADDR_W-1:0] seq_pc;
    logic [ADDR_W-1:0] br_off;
    logic [ADDR_W-1:0] br_pc;
    logic [ADDR_W-1:0] next_pc;
    next_src_e         src;

    pc_adder #(.W(ADDR_W)) u_seq_add (
        .op_a (pc_q),
        .op_b (STEP_V),
        .sum  (seq_pc)
    );

    branch_offset #(.ADDR_W(ADDR_W), .IMM_W(IMM_W), .ALIGN_W(ALIGN_W)) u_off (
        .imm      (imm_field),
        .byte_off (br_off)
    );

    pc_adder #(.W(ADDR_W)) u_br_add (
        .op_a (seq_pc),
        .op_b (br_off),
        .sum  (br_pc)
    );

    pc_path_sel u_sel (
        .is_branch (is_branch),
        .alu_zero  (alu_zero),
        .is_jump   (is_jump),
        .src       (src)
    );

    next_pc_mux #(.ADDR_W(ADDR_W), .TGT_W(TGT_W), .ALIGN_W(ALIGN_W)) u_mux (
        .src     (src),
        .seq_pc  (seq_pc),
        .br_pc   (br_pc),
        .pc_hi   (pc_q[ADDR_W-1 -: HI_W]),
        .tgt     (jump_tgt),
        .next_pc (next_pc)
    );

    always_ff @(posedge clk) begin
        if (rst)
            pc_q <= '0;
        else
            pc_q <= next_pc;
    end

    assign fetch_addr = pc_q;
endmodule

// File: rtl/pc_fetch_seq_chk.sv
module pc_fetch_seq_chk #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned IMM_W  = 16,
    parameter int unsigned TGT_W  = 26,
    parameter int unsigned STEP   = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              is_branch,
    input logic              alu_zero,
    input logic              is_jump,
    input logic [IMM_W-1:0]  imm_field,
    input logic [TGT_W-1:0]  jump_tgt,
    input logic [ADDR_W-1:0] fetch_addr
);
    localparam int unsigned AL = $clog2(STEP);
    localparam int unsigned HI = ADDR_W - TGT_W - AL;
    localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(STEP);

    logic signed [ADDR_W-1:0] off_chk;
    always_comb off_chk = ADDR_W'($signed(imm_field)) * ADDR_W'(STEP);

    // R1: the first cycle out of reset sees address 0
    p_reset_zero_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> fetch_addr == '0);

    // R2, R4: no jump and no qualified branch means a plain step
    p_seq_step_r2: assert property (@(posedge clk) disable iff (rst)
        (!is_jump && !(is_branch && alu_zero)) |=> fetch_addr == $past(fetch_addr) + STEP_V);

    // R3, R8: a taken branch adds the scaled offset to PC + 4, modulo 2^32
    p_branch_r3: assert property (@(posedge clk) disable iff (rst)
        (is_branch && alu_zero && !is_jump) |=>
            fetch_addr == $past(fetch_addr) + STEP_V + $past(off_chk));

    // R5, R6: a jump splices the target whatever the branch qualifiers say
    p_jump_r5: assert property (@(posedge clk) disable iff (rst)
        is_jump |=> fetch_addr == {$past(fetch_addr[ADDR_W-1 -: HI]), $past(jump_tgt), {AL{1'b0}}});

    // R7: alignment bits stay clear
    p_aligned_r7: assert property (@(posedge clk) disable iff (rst)
        fetch_addr[AL-1:0] == '0);
endmodule

bind pc_fetch_seq pc_fetch_seq_chk #(
    .ADDR_W(ADDR_W), .IMM_W(IMM_W), .TGT_W(TGT_W), .STEP(STEP)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .is_branch  (is_branch),
    .alu_zero   (alu_zero),
    .is_jump    (is_jump),
    .imm_field  (imm_field),
    .jump_tgt   (jump_tgt),
    .fetch_addr (fetch_addr)
);

// File: tb/sim_pc_fetch_seq.sv
`timescale 1ns/1ps
module sim_pc_fetch_seq;
    logic        clk = 1'b0;
    logic        rst;
    logic        is_branch;
    logic        alu_zero;
    logic        is_jump;
    logic [15:0] imm_field;
    logic [25:0] jump_tgt;
    logic [31:0] fetch_addr;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    pc_fetch_seq u0 (
        .clk        (clk),
        .rst        (rst),
        .is_branch  (is_branch),
        .alu_zero   (alu_zero),
        .is_jump    (is_jump),
        .imm_field  (imm_field),
        .jump_tgt   (jump_tgt),
        .fetch_addr (fetch_addr)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    // Drive inputs, take one rising edge, settle 1 ns after it
    task automatic step(input logic b, input logic z, input logic j,
                        input logic [15:0] imm, input logic [25:0] tg);
        is_branch = b; alu_zero = z; is_jump = j; imm_field = imm; jump_tgt = tg;
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        step(1'b0, 1'b0, 1'b0, 16'h0, 26'h0);
        rst = 1'b0;
    endtask

    task automatic t_reset_r1();
        do_reset();
        chk("R1 reset value", fetch_addr, 32'h0);
    endtask

    task automatic t_seq_r2();
        step(1'b0, 1'b0, 1'b0, 16'hABCD, 26'h155);
        chk("R2 step 1", fetch_addr, 32'h4);
        step(1'b0, 1'b0, 1'b0, 16'h0001, 26'h0);
        chk("R2 step 2", fetch_addr, 32'h8);
        step(1'b0, 1'b0, 1'b0, 16'h0, 26'h0);
        chk("R2 step 3", fetch_addr, 32'hC);
    endtask

    task automatic t_branch_r3();
        step(1'b1, 1'b1, 1'b0, 16'h0003, 26'h0);   // 0xC + 4 + 12
        chk("R3 forward branch", fetch_addr, 32'h1C);
        step(1'b1, 1'b1, 1'b0, 16'hFFFC, 26'h0);   // 0x1C + 4 - 16
        chk("R3 backward branch", fetch_addr, 32'h10);
    endtask

    task automatic t_half_qual_r4();
        step(1'b1, 1'b0, 1'b0, 16'h0040, 26'h0);
        chk("R4 branch without zero", fetch_addr, 32'h14);
        step(1'b0, 1'b1, 1'b0, 16'h0040, 26'h0);
        chk("R4 zero without branch", fetch_addr, 32'h18);
    endtask

    task automatic t_jump_r5();
        step(1'b0, 1'b0, 1'b1, 16'h0, 26'h0000123);
        chk("R5 jump low nibble 0", fetch_addr, 32'h0000048C);
    endtask

    task automatic t_override_r6();
        step(1'b1, 1'b1, 1'b1, 16'h0005, 26'h3FFFFFF);
        chk("R6 jump beats taken branch", fetch_addr, 32'h0FFFFFFC);
        step(1'b1, 1'b0, 1'b1, 16'h0005, 26'h0000010);
        chk("R6 jump with branch no zero", fetch_addr, 32'h00000040);
    endtask

    task automatic t_wrap_r8();
        do_reset();
        step(1'b1, 1'b1, 1'b0, 16'hFFFE, 26'h0);   // 0 + 4 - 8
        chk("R8 backward wrap", fetch_addr, 32'hFFFFFFFC);
        step(1'b0, 1'b0, 1'b0, 16'h0, 26'h0);
        chk("R8 sequential wrap", fetch_addr, 32'h0);
        step(1'b1, 1'b1, 1'b0, 16'hFFFE, 26'h0);
        chk("R8 backward wrap again", fetch_addr, 32'hFFFFFFFC);
        step(1'b0, 1'b0, 1'b1, 16'h0, 26'h0000015);
        chk("R5 jump keeps top nibble F", fetch_addr, 32'hF0000054);
        step(1'b1, 1'b1, 1'b0, 16'h7FFF, 26'h0);   // 0xF0000058 + 0x1FFFC
        chk("R3 max positive offset", fetch_addr, 32'hF0020054);
    endtask

    task automatic t_align_r7();
        step(1'b1, 1'b1, 1'b0, 16'h8001, 26'h0);
        chk("R7 low bits after branch", {30'h0, fetch_addr[1:0]}, 32'h0);
        step(1'b0, 1'b0, 1'b1, 16'h0, 26'h2AAAAAA);
        chk("R7 low bits after jump", {30'h0, fetch_addr[1:0]}, 32'h0);
    endtask

    task automatic t_reset_mid_r1();
        rst = 1'b1;
        step(1'b1, 1'b1, 1'b1, 16'h0010, 26'h3FFFFFF);
        chk("R1 reset beats jump", fetch_addr, 32'h0);
        rst = 1'b0;
        step(1'b0, 1'b0, 1'b0, 16'h0, 26'h0);
        chk("R2 step after reset", fetch_addr, 32'h4);
    endtask

    initial begin
        rst = 1'b1; is_branch = 1'b0; alu_zero = 1'b0; is_jump = 1'b0;
        imm_field = '0; jump_tgt = '0;
        t_reset_r1();
        t_seq_r2();
        t_branch_r3();
        t_half_qual_r4();
        t_jump_r5();
        t_override_r6();
        t_wrap_r8();
        t_align_r7();
        t_reset_mid_r1();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule